// File: doc/BRIEF.md
# Serial Word Boundary Aligner

This block sits behind a deserializer that hands over 10 received bits per clock with an arbitrary bit phase. It keeps the two most recent raw words as a 20-bit window, and it picks one of ten bit offsets in that window as the word boundary. The word at that offset is the aligned output. A static mode input chooses how the offset is set.

In manual mode a rising edge on the realign request starts a search. On each cycle of the search all ten candidate words are compared with a programmable alignment pattern. The first cycle that has a hit locks the boundary to the lowest matching offset and raises the sync status output for one cycle. While the aligner runs, a pattern-detect pulse marks every cycle in which the word at the current boundary holds the pattern. The pattern is 10 bits wide, or only its 7 least significant bits are compared when the short-pattern input is set.

In bit-slip mode no pattern is used. Each toggle of the slip input moves the boundary by one bit, and the realign request is ignored. The status and detect outputs stay low in this mode.

Top module: `wbnd_aligner`

## Requirements
- R1: After reset, data_out, sync_pulse and pat_det are 0, and the boundary offset is 0.
- R2: Offset k selects bits k through k+9 of the window {newer word, older word}, where the older word occupies bits 9:0. A raw word presented before clock edge n moves into the older half at edge n+1, and data_out is registered from the window at edge n+2. With offset 0, each raw word therefore appears on data_out two edges after it is sampled.
- R3: In manual mode only a 0-to-1 change of realign_req, seen across two consecutive clock edges, starts a search. Holding the request high starts no further search.
- R4: During a search, the first cycle in which any offset matches sets the offset to the lowest matching one. data_out uses the new offset from the following edge onwards.
- R5: sync_pulse is high for one cycle on the edge where a search locks. It is never high without a search in progress.
- R6: In manual mode, pat_det is high for one cycle after each cycle in which the candidate at the current offset matches the pattern.
- R7: When pat_short is 1, only bits 6:0 of a candidate are compared with align_pat[6:0]. Bits 9:7 are ignored.
- R8: A fresh rising edge of realign_req after a lock starts a new search, which may move the boundary to a different offset.
- R9: In bit-slip mode (mode_slip = 1) realign_req has no effect on the offset.
- R10: In bit-slip mode every change of level on slip_req advances the offset by one on the next edge, wrapping from 9 to 0. The offset stays in the range 0 to 9.
- R11: In bit-slip mode sync_pulse and pat_det stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_in | input | 10 | Raw parallel word from the deserializer |
| realign_req | input | 1 | Search request, acts on its rising edge (manual mode) |
| slip_req | input | 1 | Slip request, each toggle moves the boundary one bit (bit-slip mode) |
| align_pat | input | 10 | Alignment pattern |
| pat_short | input | 1 | 1: compare only the 7 low bits of the pattern |
| mode_slip | input | 1 | 0: manual pattern mode, 1: bit-slip mode (static) |
| data_out | output | 10 | Aligned word |
| sync_pulse | output | 1 | One-cycle pulse when a search locks |
| pat_det | output | 1 | One-cycle pulse when the pattern sits at the current boundary |

## Verification
The hardest case to reach is a request that is held high after a lock while the pattern reappears at a different offset. Here the aligner must not relock. Later, after the request drops and rises again, it must move to the new offset. The stimulus builds 20-bit windows in which the pattern is placed at a chosen offset and the other bits are random. It sends them as an older/newer word pair while it steps the request through held, dropped and raised phases. A reference model checks every cycle, so random bits that also match at a lower offset are handled correctly.

// File: rtl/wbnd_pkg.sv
// Package: shared types and helpers for the word boundary aligner.
// Assumes the offset range is 0 .. word width - 1.
package wbnd_pkg;

    // Boundary control mode, fixed while the block runs
    typedef enum logic {
        MODE_MANUAL = 1'b0,
        MODE_SLIP   = 1'b1
    } wbnd_mode_e;

    // Next slip offset with wrap at the last legal value
    function automatic logic [7:0] wbnd_next_off(input logic [7:0] cur, input logic [7:0] last);
        return (cur == last) ? 8'd0 : cur + 8'd1;
    endfunction

endpackage

// File: rtl/wbnd_window.sv
// Module: wbnd_window
// Holds the last two raw words as a 2W-bit window, the older word in the
// low half. Exposes every W-bit candidate and registers the candidate at
// the current offset as the aligned word.
// Assumes off stays below W. A larger value selects zero.
module wbnd_window #(
    parameter int unsigned W    = 10,
    parameter int unsigned OFFW = $clog2(W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        raw_in,
    input  logic [OFFW-1:0]     off,
    output logic [W-1:0][W-1:0] cand,
    output logic [W-1:0]        data_out
);

    localparam int unsigned WIN_W = 2 * W;

    logic [W-1:0]     raw_q;
    logic [W-1:0]     raw_qq;
    logic [WIN_W-1:0] win;
    logic [W-1:0]     sel;

    // Shift the two-word history register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            raw_qq <= '0;
        end else begin
            raw_q  <= raw_in;
            raw_qq <= raw_q;
        end
    end

    assign win = {raw_q, raw_qq};

    // One candidate slice per bit offset
    for (genvar k = 0; k < W; k++) begin : g_cand
        assign cand[k] = win[k +: W];
    end

    // Select the candidate at the current offset
    always_comb begin
        sel = '0;
        for (int k = 0; k < W; k++) begin
            if (off == OFFW'(k)) sel = cand[k];
        end
    end

    // Register the aligned word
    always_ff @(posedge clk) begin
        if (!rst_n) data_out <= '0;
        else        data_out <= sel;
    end

endmodule

// File: rtl/wbnd_match.sv
// Module: wbnd_match
// Compares every candidate with the pattern in parallel, either the full
// width or only the SW low bits. Reports whether any offset matches, the
// lowest matching offset, and whether the current offset matches.
// Assumes SW <= W.
module wbnd_match #(
    parameter int unsigned W    = 10,
    parameter int unsigned SW   = 7,
    parameter int unsigned OFFW = $clog2(W)
) (
    input  logic [W-1:0][W-1:0] cand,
    input  logic [W-1:0]        pat,
    input  logic                pat_short,
    input  logic [OFFW-1:0]     off,
    output logic                any_hit,
    output logic [OFFW-1:0]     low_off,
    output logic                cur_hit
);

    logic [W-1:0] hit;

    // Per-offset comparator
    for (genvar k = 0; k < W; k++) begin : g_cmp
        assign hit[k] = pat_short ? (cand[k][SW-1:0] == pat[SW-1:0])
                                  : (cand[k] == pat);
    end

    assign any_hit = |hit;

    // Priority encode: the lowest offset wins
    always_comb begin
        low_off = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hit[k]) low_off = OFFW'(k);
        end
    end

    // Hit at the offset now in use
    always_comb begin
        cur_hit = 1'b0;
        for (int k = 0; k < W; k++) begin
            if (off == OFFW'(k)) cur_hit = hit[k];
        end
    end

endmodule

// File: rtl/wbnd_ctrl.sv
// Module: wbnd_ctrl
// Owns the boundary offset. Manual mode arms a search on a rising edge of
// the realign request and locks on the first hit. Slip mode steps the
// offset on each toggle of the slip input.
// Assumes mode is static outside reset.
module wbnd_ctrl
    import wbnd_pkg::*;
#(
    parameter int unsigned W    = 10,
    parameter int unsigned OFFW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  wbnd_mode_e      mode,
    input  logic            realign_req,
    input  logic            slip_req,
    input  logic            any_hit,
    input  logic [OFFW-1:0] low_off,
    input  logic            cur_hit,
    output logic [OFFW-1:0] off,
    output logic            searching,
    output logic            rise,
    output logic            toggle,
    output logic            sync_pulse,
    output logic            pat_det
);

    localparam logic [7:0] OFF_LAST = 8'(W - 1);

    logic            req_q;
    logic            slip_q;
    logic            lock;
    logic [OFFW-1:0] slip_next;

    // Remember previous request levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            slip_q <= 1'b0;
        end else begin
            req_q  <= realign_req;
            slip_q <= slip_req;
        end
    end

    assign rise      = realign_req & ~req_q;
    assign toggle    = slip_req ^ slip_q;
    assign lock      = (mode == MODE_MANUAL) & searching & any_hit;
    assign slip_next = OFFW'(wbnd_next_off(8'(off), OFF_LAST));

    // Search arm/disarm state
    always_ff @(posedge clk) begin
        if (!rst_n)                  searching <= 1'b0;
        else if (mode == MODE_SLIP)  searching <= 1'b0;
        else                         searching <= rise | (searching & ~any_hit);
    end

    // Boundary offset update
    always_ff @(posedge clk) begin
        if (!rst_n)                              off <= '0;
        else if (mode == MODE_SLIP && toggle)    off <= slip_next;
        else if (lock)                           off <= low_off;
    end

    // Single-cycle status and detect pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_pulse <= 1'b0;
            pat_det    <= 1'b0;
        end else begin
            sync_pulse <= lock;
            pat_det    <= (mode == MODE_MANUAL) & cur_hit;
        end
    end

endmodule

// File: rtl/wbnd_aligner.sv
// Module: wbnd_aligner (top)
// Word boundary aligner for a W-bit deserialized stream, with a pattern
// search mode and a bit-slip mode. Latency from raw_in to data_out is two
// clock edges.
// Assumes mode_slip and pat_short change only while in reset.
module wbnd_aligner
    import wbnd_pkg::*;
#(
    parameter int unsigned WORD_W  = 10,
    parameter int unsigned SHORT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] raw_in,
    input  logic              realign_req,
    input  logic              slip_req,
    input  logic [WORD_W-1:0] align_pat,
    input  logic              pat_short,
    input  logic              mode_slip,
    output logic [WORD_W-1:0] data_out,
    output logic              sync_pulse,
    output logic              pat_det
);

    localparam int unsigned OFFW = $clog2(WORD_W);

    wbnd_mode_e                   mode;
    logic [WORD_W-1:0][WORD_W-1:0] cand;
    logic [OFFW-1:0]              off;
    logic [OFFW-1:0]              low_off;
    logic                         any_hit;
    logic                         cur_hit;
    logic                         searching;
    logic                         rise;
    logic                         toggle;

    assign mode = mode_slip ? MODE_SLIP : MODE_MANUAL;

    wbnd_window #(.W(WORD_W), .OFFW(OFFW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (raw_in),
        .off      (off),
        .cand     (cand),
        .data_out (data_out)
    );

    wbnd_match #(.W(WORD_W), .SW(SHORT_W), .OFFW(OFFW)) u_match (
        .cand      (cand),
        .pat       (align_pat),
        .pat_short (pat_short),
        .off       (off),
        .any_hit   (any_hit),
        .low_off   (low_off),
        .cur_hit   (cur_hit)
    );

    wbnd_ctrl #(.W(WORD_W), .OFFW(OFFW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .realign_req (realign_req),
        .slip_req    (slip_req),
        .any_hit     (any_hit),
        .low_off     (low_off),
        .cur_hit     (cur_hit),
        .off         (off),
        .searching   (searching),
        .rise        (rise),
        .toggle      (toggle),
        .sync_pulse  (sync_pulse),
        .pat_det     (pat_det)
    );

endmodule

// File: rtl/wbnd_aligner_chk.sv
// Module: wbnd_aligner_chk
// Temporal checks on the aligner, bound into every wbnd_aligner instance.
module wbnd_aligner_chk #(
    parameter int unsigned W    = 10,
    parameter int unsigned OFFW = $clog2(W)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mode_slip,
    input logic [OFFW-1:0] off,
    input logic            searching,
    input logic            rise,
    input logic            toggle,
    input logic            any_hit,
    input logic            sync_pulse,
    input logic            pat_det
);

    localparam logic [OFFW-1:0] OFF_LAST = OFFW'(W - 1);

    AST_OFF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        off <= OFF_LAST);                                                         // R10

    AST_SLIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mode_slip && toggle |=> off == (($past(off) == OFF_LAST) ? '0 : $past(off) + 1'b1)); // R10

    AST_SLIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_slip && !toggle |=> $stable(off));                                   // R9

    AST_SLIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_slip |=> !sync_pulse && !pat_det);                                   // R11

    AST_RISE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_slip && rise |=> searching);                                        // R3

    AST_NO_LOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !searching |=> !sync_pulse);                                              // R5

    AST_LOCK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_slip && searching && any_hit |=> sync_pulse);                       // R5

endmodule

bind wbnd_aligner wbnd_aligner_chk #(.W(WORD_W), .OFFW(OFFW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_slip  (mode_slip),
    .off        (off),
    .searching  (searching),
    .rise       (rise),
    .toggle     (toggle),
    .any_hit    (any_hit),
    .sync_pulse (sync_pulse),
    .pat_det    (pat_det)
);

// File: tb/sim_wbnd_aligner.sv
module sim_wbnd_aligner;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] raw_in = '0;
    logic       realign_req = 1'b0;
    logic       slip_req = 1'b0;
    logic [9:0] align_pat = 10'h17C;
    logic       pat_short = 1'b0;
    logic       mode_slip = 1'b0;
    logic [9:0] data_out;
    logic       sync_pulse;
    logic       pat_det;

    int n_vec = 0;
    int n_bad = 0;
    string ph = "R1";
    bit done = 1'b0;

    // reference model state
    logic [9:0] m_r1 = '0, m_r2 = '0, m_out = '0;
    int m_off = 0;
    bit m_srch = 0, m_reqq = 0, m_slipq = 0, m_sync = 0, m_det = 0;

    always #5 clk = ~clk;

    wbnd_aligner u0 (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .realign_req(realign_req),
        .slip_req(slip_req), .align_pat(align_pat), .pat_short(pat_short),
        .mode_slip(mode_slip), .data_out(data_out), .sync_pulse(sync_pulse),
        .pat_det(pat_det)
    );

    function automatic bit m_match(logic [19:0] win, int k);
        logic [9:0] c = 10'(win >> k);
        if (pat_short) return c[6:0] == align_pat[6:0];
        return c == align_pat;
    endfunction

    task automatic model_edge();
        logic [19:0] win = {m_r1, m_r2};
        int low = -1;
        bit rise = realign_req && !m_reqq;
        bit tog = slip_req != m_slipq;
        if (!rst_n) begin
            m_r1 = '0; m_r2 = '0; m_out = '0; m_off = 0;
            m_srch = 0; m_reqq = 0; m_slipq = 0; m_sync = 0; m_det = 0;
            return;
        end
        for (int k = 9; k >= 0; k--) if (m_match(win, k)) low = k;
        m_out = 10'(win >> m_off);
        if (mode_slip) begin
            m_sync = 0; m_det = 0; m_srch = 0;
            if (tog) m_off = (m_off + 1) % 10;
        end else begin
            m_det = m_match(win, m_off);
            m_sync = m_srch && (low >= 0);
            if (m_sync) m_off = low;
            m_srch = rise || (m_srch && low < 0);
        end
        m_r2 = m_r1; m_r1 = raw_in;
        m_reqq = realign_req; m_slipq = slip_req;
    endtask

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #2;
        check(data_out == m_out, ph, "data_out", int'(data_out), int'(m_out));
        check(sync_pulse == m_sync, mode_slip ? "R11" : "R5", "sync_pulse",
              int'(sync_pulse), int'(m_sync));
        check(pat_det == m_det, mode_slip ? "R11" : "R6", "pat_det",
              int'(pat_det), int'(m_det));
    endtask

    task automatic rnd_ticks(int n);
        for (int i = 0; i < n; i++) begin
            raw_in = 10'($urandom);
            tick();
        end
    endtask

    // place the pattern at offset k as an older/newer word pair
    task automatic put_pat(int k);
        logic [19:0] v = 20'($urandom);
        if (pat_short) begin
            v[k +: 7] = align_pat[6:0];
            v[k + 7 +: 3] = ~align_pat[9:7];
        end else begin
            v[k +: 10] = align_pat;
        end
        raw_in = v[9:0];
        tick();
        raw_in = v[19:10];
        tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        realign_req = 1'b0;
        slip_req = 1'b0;
        raw_in = '0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #1;
        do_reset();
        // R1: literal reset values
        check(data_out == 10'd0, "R1", "data_out after reset", int'(data_out), 0);
        check(sync_pulse == 1'b0, "R1", "sync_pulse after reset", int'(sync_pulse), 0);
        check(pat_det == 1'b0, "R1", "pat_det after reset", int'(pat_det), 0);

        // R2: pass-through at offset 0, two-edge latency
        ph = "R2";
        raw_in = 10'h2A5;
        tick();
        raw_in = 10'h0F3;
        tick();
        check(data_out == 10'h000, "R2", "before latency", int'(data_out), 0);
        raw_in = 10'h111;
        tick();
        check(data_out == 10'h2A5, "R2", "first word out", int'(data_out), 'h2A5);
        rnd_ticks(12);

        // R4: search then lock at offset 3
        ph = "R4";
        realign_req = 1'b1;
        tick();
        put_pat(3);
        rnd_ticks(6);

        // R3: request held high, pattern elsewhere must not relock
        ph = "R3";
        put_pat(6);
        rnd_ticks(4);
        put_pat(3);
        rnd_ticks(4);

        // R8: new rising edge after lock moves the boundary
        ph = "R8";
        realign_req = 1'b0;
        tick();
        realign_req = 1'b1;
        tick();
        put_pat(6);
        rnd_ticks(5);
        put_pat(6);
        rnd_ticks(3);

        // R7: short pattern, upper three bits differ
        ph = "R7";
        pat_short = 1'b1;
        align_pat = 10'h3C5;
        do_reset();
        realign_req = 1'b1;
        tick();
        put_pat(5);
        rnd_ticks(4);
        put_pat(5);
        rnd_ticks(4);

        // R9: bit-slip mode ignores realign
        ph = "R9";
        pat_short = 1'b0;
        align_pat = 10'h17C;
        mode_slip = 1'b1;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            realign_req = ~realign_req;
            put_pat(2);
        end
        realign_req = 1'b0;

        // R10: slip toggles step the offset and wrap past 9
        ph = "R10";
        for (int i = 0; i < 13; i++) begin
            slip_req = ~slip_req;
            rnd_ticks(1 + (i % 3));
        end
        rnd_ticks(4);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule